// File: doc/BRIEF.md
# Dual-Sided Processor Messaging Unit

This block joins two processors, side A and side B, through a shared set of mailbox words. Each side has its own register window on a simple bus with an address, a write strobe, a read strobe and 32-bit data. It also has one interrupt line. A side sends a word by writing one of its four transmit slots. The same word then appears in the matching receive slot of the other side. A pair of flags follows each slot: receive-full on the reading side and transmit-empty on the writing side. Software on both ends can therefore pace a stream of words without losing any of them.

Each direction also carries four doorbells. A side rings a doorbell by setting a request bit in its control word. The far side then sees a pending bit, which it clears by writing a one to it. Clearing the pending bit also withdraws the request. Both side's interrupt lines combine the three event kinds with their enables. Either side can restart the whole unit through a self-clearing reset request. The unit reports that reset as busy for a fixed number of cycles.

Top module: `msg_unit`

## Requirements
- R1: After reset, each side's status word (offset 0x20) reads 0x00F0_0000 (all four transmit-empty flags set), its control word (offset 0x24) reads 0, and both interrupt lines are low.
- R2: A write to transmit slot n (offset 4n, n = 0..3) stores the word in the far side's receive slot n (offset 0x10 + 4n). From the next cycle the far side's receive-full n (status bit 27−n) is set and the writer's transmit-empty n (status bit 23−n) is clear.
- R3: A read of receive slot n returns the stored word. It clears receive-full n on the reader and sets transmit-empty n on the writer. The stored word does not change.
- R4: When the reader consumes slot n in the same cycle as the writer refills it, the receive-full flag stays set and the next read returns the new word.
- R5: A control-word write with request bit 19−n set makes doorbell n pending on the far side (status bit 31−n). Until that pending bit clears, the writer's control word reads request bit 19−n as 1.
- R6: Status doorbell bits clear when written with 1. Bits written with 0 keep their value, and writes to any other status bit do nothing. Writing back the value just read clears every pending doorbell.
- R7: A control-word write loads three enable groups: doorbell enable n (bit 31−n), receive enable n (bit 27−n) and transmit enable n (bit 23−n). The interrupt line of a side is high exactly when some enabled doorbell-pending, receive-full or transmit-empty flag of that side is set.
- R8: A control write with bit 5 set clears all slots, flags, doorbells and enables on both sides in the next cycle. For the following RST_CYCLES cycles, status bit 7 and control bit 5 read 1 on both sides. After that, both sides read their reset values.
- R9: While that reset is in progress, writes and reads from either side have no effect.
- R10: Reads of transmit slots, of unaligned addresses and of unmapped offsets return 0. Writes to receive slots or to unmapped offsets change nothing.
- R11: A stream of six or more words in each direction, sent through all four slots in turn and paced only by the flags, arrives complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Side A byte address |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (side effects only) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for the addressed word |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | ADDR_W | Side B byte address |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (side effects only) |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for the addressed word |
| b_irq | output | 1 | Side B interrupt |

## Verification
The read data shows the addressed word of the current state at all times. The strobes only cause side effects. Because of this, a wrong flag, slot word, enable or doorbell bit shows up in the very cycle that the bench addresses it. Comparing both read buses and both interrupt lines against a behavioural model on every clock catches a bad state within one cycle of its creation, as long as the bench is looking at that word. A mistake on a flag the bench does not address becomes visible at the latest through the interrupt line, when the matching enable is set, or on the next status poll.

// File: rtl/msgu_pkg.sv
package msgu_pkg;

    localparam int NCH  = 4;
    localparam int DW   = 32;
    localparam int CH_W = $clog2(NCH);

    // bit groups; channel n occupies base + NCH-1-n
    localparam int GP_BASE  = 28;
    localparam int RF_BASE  = 24;
    localparam int TE_BASE  = 20;
    localparam int GR_BASE  = 16;
    localparam int BUSY_BIT = 7;
    localparam int RSTQ_BIT = 5;

    localparam int TX_WORD0 = 0;
    localparam int RX_WORD0 = NCH;
    localparam int ST_WORD  = 2 * NCH;
    localparam int CT_WORD  = 2 * NCH + 1;

    typedef logic [NCH-1:0] chmask_t;
    typedef logic [DW-1:0]  word_t;

    typedef enum logic [2:0] {RG_NONE, RG_TX, RG_RX, RG_STAT, RG_CTRL} region_e;

    typedef struct packed {
        region_e         rg;
        logic [CH_W-1:0] ch;
    } dec_t;

    typedef struct packed {
        chmask_t bell_en;
        chmask_t rx_en;
        chmask_t tx_en;
    } irq_en_t;

    function automatic chmask_t flip(chmask_t v);
        chmask_t r;
        for (int i = 0; i < NCH; i++) r[i] = v[NCH-1-i];
        return r;
    endfunction

    function automatic chmask_t field(word_t w, int base);
        return flip(w[base +: NCH]);
    endfunction

    function automatic dec_t decode(int unsigned a);
        dec_t        d;
        int unsigned w;
        d.rg = RG_NONE;
        d.ch = '0;
        w    = a >> 2;
        if (a[1:0] == 2'b00) begin
            if (w < RX_WORD0) begin
                d.rg = RG_TX;
                d.ch = CH_W'(w - TX_WORD0);
            end else if (w < ST_WORD) begin
                d.rg = RG_RX;
                d.ch = CH_W'(w - RX_WORD0);
            end else if (w == ST_WORD) begin
                d.rg = RG_STAT;
            end else if (w == CT_WORD) begin
                d.rg = RG_CTRL;
            end
        end
        return d;
    endfunction

    function automatic word_t pack_stat(chmask_t pend, chmask_t full, chmask_t empty, logic busy);
        word_t r = '0;
        r[GP_BASE +: NCH] = flip(pend);
        r[RF_BASE +: NCH] = flip(full);
        r[TE_BASE +: NCH] = flip(empty);
        r[BUSY_BIT]       = busy;
        return r;
    endfunction

    function automatic word_t pack_ctrl(irq_en_t en, chmask_t req, logic busy);
        word_t r = '0;
        r[GP_BASE +: NCH] = flip(en.bell_en);
        r[RF_BASE +: NCH] = flip(en.rx_en);
        r[TE_BASE +: NCH] = flip(en.tx_en);
        r[GR_BASE +: NCH] = flip(req);
        r[RSTQ_BIT]       = busy;
        return r;
    endfunction

endpackage

// File: rtl/msgu_lane.sv
module msgu_lane
    import msgu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  chmask_t                wr_en,
    input  word_t                  wdata,
    input  chmask_t                rd_en,
    output chmask_t                full,
    output logic [NCH-1:0][DW-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            full <= '0;
            data <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (wr_en[n]) begin
                    data[n] <= wdata;
                    full[n] <= 1'b1;
                end else if (rd_en[n]) begin
                    full[n] <= 1'b0;
                end
            end
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        AST_FILL_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
            (wr_en[n] && !clr) |=> full[n]); // R2
        AST_READ_DRAINS: assert property (@(posedge clk) disable iff (rst)
            (rd_en[n] && !wr_en[n] && !clr) |=> !full[n]); // R3
        AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
            (!wr_en[n] && !clr) |=> $stable(data[n])); // R3
    end

endmodule

// File: rtl/msgu_bell.sv
module msgu_bell
    import msgu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  chmask_t ring,
    input  chmask_t ack,
    output chmask_t pend
);

    always_ff @(posedge clk) begin
        if (rst || clr) pend <= '0;
        else            pend <= (pend & ~ack) | ring;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        AST_RING_PENDS: assert property (@(posedge clk) disable iff (rst)
            (ring[n] && !clr) |=> pend[n]); // R5
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack[n] && !ring[n] && !clr) |=> !pend[n]); // R6
    end

endmodule

// File: rtl/msgu_port.sv
module msgu_port
    import msgu_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   busy,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr,
    input  logic                   rd,
    input  word_t                  wdata,
    input  chmask_t                in_full,
    input  logic [NCH-1:0][DW-1:0] in_data,
    input  chmask_t                out_full,
    input  chmask_t                in_pend,
    input  chmask_t                out_pend,
    output chmask_t                tx_we,
    output chmask_t                rx_re,
    output chmask_t                ring,
    output chmask_t                ack,
    output logic                   rst_req,
    output word_t                  rdata,
    output logic                   irq
);

    dec_t    d;
    irq_en_t en;
    logic    wr_ok;
    logic    rd_ok;

    assign d     = decode(32'(addr));
    assign wr_ok = wr && !busy;
    assign rd_ok = rd && !busy;

    always_comb begin
        tx_we   = '0;
        rx_re   = '0;
        ring    = '0;
        ack     = '0;
        rst_req = 1'b0;
        rdata   = '0;
        unique case (d.rg)
            RG_TX: tx_we[d.ch] = wr_ok;
            RG_RX: begin
                rx_re[d.ch] = rd_ok;
                rdata       = in_data[d.ch];
            end
            RG_STAT: begin
                ack   = wr_ok ? field(wdata, GP_BASE) : '0;
                rdata = pack_stat(in_pend, in_full, ~out_full, busy);
            end
            RG_CTRL: begin
                ring    = wr_ok ? field(wdata, GR_BASE) : '0;
                rst_req = wr_ok && wdata[RSTQ_BIT];
                rdata   = pack_ctrl(en, out_pend, busy);
            end
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            en <= '0;
        end else if (wr_ok && d.rg == RG_CTRL) begin
            en.bell_en <= field(wdata, GP_BASE);
            en.rx_en   <= field(wdata, RF_BASE);
            en.tx_en   <= field(wdata, TE_BASE);
        end
    end

    assign irq = (|(~out_full & en.tx_en)) | (|(in_full & en.rx_en)) | (|(in_pend & en.bell_en));

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq); // R8
    AST_NO_EFFECT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(en)); // R9

endmodule

// File: rtl/msg_unit.sv
module msg_unit
    import msgu_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata,
    output logic              b_irq
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [ADDR_W-1:0]      s_addr [2];
    logic                   s_wr   [2];
    logic                   s_rd   [2];
    word_t                  s_wd   [2];
    word_t                  s_rdat [2];
    logic                   s_irq  [2];
    chmask_t                tx_we  [2];
    chmask_t                rx_re  [2];
    chmask_t                ring   [2];
    chmask_t                ack    [2];
    logic                   rreq   [2];
    chmask_t                lane_full [2];
    logic [NCH-1:0][DW-1:0] lane_data [2];
    chmask_t                bell_pend [2];

    logic             clr;
    logic             busy;
    logic [CNT_W-1:0] rst_cnt;

    assign s_addr[0] = a_addr;  assign s_addr[1] = b_addr;
    assign s_wr[0]   = a_wr;    assign s_wr[1]   = b_wr;
    assign s_rd[0]   = a_rd;    assign s_rd[1]   = b_rd;
    assign s_wd[0]   = a_wdata; assign s_wd[1]   = b_wdata;
    assign a_rdata   = s_rdat[0];
    assign b_rdata   = s_rdat[1];
    assign a_irq     = s_irq[0];
    assign b_irq     = s_irq[1];

    assign clr  = rreq[0] || rreq[1];
    assign busy = (rst_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)       rst_cnt <= '0;
        else if (clr)  rst_cnt <= CNT_W'(RST_CYCLES);
        else if (busy) rst_cnt <= rst_cnt - CNT_W'(1);
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        msgu_port #(.ADDR_W(ADDR_W)) u_port (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr),
            .busy     (busy),
            .addr     (s_addr[s]),
            .wr       (s_wr[s]),
            .rd       (s_rd[s]),
            .wdata    (s_wd[s]),
            .in_full  (lane_full[1-s]),
            .in_data  (lane_data[1-s]),
            .out_full (lane_full[s]),
            .in_pend  (bell_pend[1-s]),
            .out_pend (bell_pend[s]),
            .tx_we    (tx_we[s]),
            .rx_re    (rx_re[s]),
            .ring     (ring[s]),
            .ack      (ack[s]),
            .rst_req  (rreq[s]),
            .rdata    (s_rdat[s]),
            .irq      (s_irq[s])
        );

        // words and doorbells travelling from side s to the other side
        msgu_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .wr_en (tx_we[s]),
            .wdata (s_wd[s]),
            .rd_en (rx_re[1-s]),
            .full  (lane_full[s]),
            .data  (lane_data[s])
        );

        msgu_bell u_bell (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .ring (ring[s]),
            .ack  (ack[1-s]),
            .pend (bell_pend[s])
        );
    end

    AST_BUSY_ON_REQUEST: assert property (@(posedge clk) disable iff (rst)
        clr |=> busy); // R8
    AST_RESET_WIPES: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (lane_full[0] == '0 && lane_full[1] == '0 &&
                         bell_pend[0] == '0 && bell_pend[1] == '0)); // R8
    AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (busy && rst_cnt > CNT_W'(1)) |=> busy); // R8

endmodule

// File: tb/test_msg_unit.sv
module test_msg_unit;

    localparam int RST_CYC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  ad [2];
    logic        wr [2];
    logic        rd [2];
    logic [31:0] wd [2];
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    msg_unit #(.ADDR_W(6), .RST_CYCLES(RST_CYC)) i_msg_unit (
        .clk(clk), .rst(rst),
        .a_addr(ad[0]), .a_wr(wr[0]), .a_rd(rd[0]), .a_wdata(wd[0]),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(ad[1]), .b_wr(wr[1]), .b_rd(rd[1]), .b_wdata(wd[1]),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // behavioural model: [s] = state seen by side s as receiver
    logic [31:0] m_data [2][4];
    bit          m_full [2][4];
    bit          m_pend [2][4];
    bit          m_tie  [2][4];
    bit          m_rie  [2][4];
    bit          m_gie  [2][4];
    int          m_busy;

    function automatic logic [31:0] rdat(int s);
        return (s == 0) ? a_rdata : b_rdata;
    endfunction

    function automatic logic irqo(int s);
        return (s == 0) ? a_irq : b_irq;
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                m_data[s][n] = '0; m_full[s][n] = 0; m_pend[s][n] = 0;
                m_tie[s][n] = 0; m_rie[s][n] = 0; m_gie[s][n] = 0;
            end
    endfunction

    function automatic logic [31:0] model_rdata(int s, logic [5:0] a);
        logic [31:0] r = '0;
        int w = int'(a) / 4;
        if (a[1:0] != 2'b00) return '0;
        if (w >= 4 && w < 8) return m_data[s][w-4];
        if (w == 8) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_pend[s][n];
                r[27-n] = m_full[s][n];
                r[23-n] = !m_full[1-s][n];
            end
            r[7] = (m_busy > 0);
        end else if (w == 9) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_gie[s][n];
                r[27-n] = m_rie[s][n];
                r[23-n] = m_tie[s][n];
                r[19-n] = m_pend[1-s][n];
            end
            r[5] = (m_busy > 0);
        end
        return r;
    endfunction

    function automatic logic model_irq(int s);
        logic r = 0;
        for (int n = 0; n < 4; n++)
            r |= (!m_full[1-s][n] && m_tie[s][n]) || (m_full[s][n] && m_rie[s][n]) ||
                 (m_pend[s][n] && m_gie[s][n]);
        return r;
    endfunction

    function automatic void model_step();
        bit req = 0;
        bit busy = (m_busy > 0);
        for (int s = 0; s < 2; s++)
            if (!busy && wr[s] && ad[s] == 6'h24 && wd[s][5]) req = 1;
        if (req) begin model_clear(); m_busy = RST_CYC; return; end
        if (busy) begin m_busy--; return; end
        for (int s = 0; s < 2; s++) begin
            if (rd[s] && ad[s] >= 6'h10 && ad[s] <= 6'h1C && ad[s][1:0] == 0)
                m_full[s][(int'(ad[s]) - 16) / 4] = 0;
            if (wr[s] && ad[s] == 6'h20)
                for (int n = 0; n < 4; n++) if (wd[s][31-n]) m_pend[s][n] = 0;
        end
        for (int s = 0; s < 2; s++) begin
            if (wr[s] && ad[s] < 6'h10 && ad[s][1:0] == 0) begin
                m_data[1-s][int'(ad[s]) / 4] = wd[s];
                m_full[1-s][int'(ad[s]) / 4] = 1;
            end
            if (wr[s] && ad[s] == 6'h24)
                for (int n = 0; n < 4; n++) begin
                    m_gie[s][n] = wd[s][31-n];
                    m_rie[s][n] = wd[s][27-n];
                    m_tie[s][n] = wd[s][23-n];
                    if (wd[s][19-n]) m_pend[1-s][n] = 1;
                end
        end
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // one clock: compare against the model, advance it, release strobes
    task automatic tick(string tag);
        #2;
        for (int s = 0; s < 2; s++) begin
            check(tag, "model rdata", rdat(s), model_rdata(s, ad[s]));
            check(tag, "model irq", 32'(irqo(s)), 32'(model_irq(s)));
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin wr[s] = 0; rd[s] = 0; end
    endtask

    task automatic op_wr(int s, logic [5:0] a, logic [31:0] d, string tag);
        ad[s] = a; wd[s] = d; wr[s] = 1;
        tick(tag);
    endtask

    task automatic op_rd(int s, logic [5:0] a, string tag, output logic [31:0] v);
        ad[s] = a; rd[s] = 1;
        #1 v = rdat(s);
        tick(tag);
    endtask

    task automatic peek(int s, logic [5:0] a, logic [31:0] exp, string tag);
        ad[s] = a;
        #1 check(tag, "value", rdat(s), exp);
        tick(tag);
    endtask

    task automatic wait_flag(int s, int bitpos, string tag);
        logic seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            ad[s] = 6'h20;
            #1 seen = rdat(s)[bitpos];
            tick(tag);
        end
        check(tag, "flag poll", 32'(seen), 32'd1);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin ad[s] = 6'h20; wr[s] = 0; rd[s] = 0; wd[s] = '0; end
        model_clear();
        m_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        peek(0, 6'h20, 32'h00F0_0000, "R1");
        peek(1, 6'h20, 32'h00F0_0000, "R1");
        peek(0, 6'h24, 32'h0, "R1");
        check("R1", "irq a", 32'(a_irq), 0);
        check("R1", "irq b", 32'(b_irq), 0);

        // R2 / R3 word transfer A to B on every slot
        for (int n = 0; n < 4; n++) op_wr(0, 6'(4 * n), 32'h1111_0000 + n, "R2");
        peek(1, 6'h20, 32'h0FF0_0000, "R2");
        peek(0, 6'h20, 32'h0000_0000, "R2");
        for (int n = 0; n < 4; n++) begin
            op_rd(1, 6'(16 + 4 * n), "R3", v);
            check("R3", "rx word", v, 32'h1111_0000 + n);
        end
        peek(1, 6'h20, 32'h00F0_0000, "R3");
        peek(0, 6'h20, 32'h00F0_0000, "R3");
        peek(1, 6'h14, 32'h1111_0001, "R3");

        // R4 drain and refill in the same cycle
        op_wr(0, 6'h04, 32'hAAAA_0001, "R4");
        ad[0] = 6'h04; wd[0] = 32'hBBBB_0002; wr[0] = 1;
        ad[1] = 6'h14; rd[1] = 1;
        #1 check("R4", "old word", b_rdata, 32'hAAAA_0001);
        tick("R4");
        peek(1, 6'h20, 32'h04F0_0000, "R4");
        op_rd(1, 6'h14, "R4", v);
        check("R4", "new word", v, 32'hBBBB_0002);

        // R5 / R6 doorbells
        op_wr(0, 6'h24, 32'h0009_0000, "R5");
        peek(1, 6'h20, 32'h90F0_0000, "R5");
        peek(0, 6'h24, 32'h0009_0000, "R5");
        op_wr(1, 6'h20, 32'h0FFF_FFFF, "R6");
        peek(1, 6'h20, 32'h90F0_0000, "R6");
        op_wr(1, 6'h20, 32'h8000_0000, "R6");
        peek(1, 6'h20, 32'h10F0_0000, "R6");
        peek(0, 6'h24, 32'h0001_0000, "R5");
        op_wr(1, 6'h20, 32'h10F0_0000, "R6");
        peek(1, 6'h20, 32'h00F0_0000, "R6");
        peek(0, 6'h24, 32'h0000_0000, "R6");

        // R7 interrupts
        op_wr(1, 6'h24, 32'h0200_0000, "R7");
        check("R7", "irq b idle", 32'(b_irq), 0);
        op_wr(0, 6'h08, 32'hC0DE_0002, "R7");
        #1 check("R7", "irq b rx", 32'(b_irq), 1);
        op_rd(1, 6'h18, "R7", v);
        #1 check("R7", "irq b drained", 32'(b_irq), 0);
        op_wr(0, 6'h24, 32'h0080_0000, "R7");
        #1 check("R7", "irq a tx empty", 32'(a_irq), 1);
        op_wr(0, 6'h00, 32'h0000_0F00, "R7");
        #1 check("R7", "irq a tx busy", 32'(a_irq), 0);
        op_wr(1, 6'h24, 32'h4000_0000, "R7");
        op_wr(0, 6'h24, 32'h0004_0000, "R7");
        #1 check("R7", "irq b bell", 32'(b_irq), 1);
        op_wr(1, 6'h20, 32'h4000_0000, "R7");
        #1 check("R7", "irq b bell clear", 32'(b_irq), 0);

        // R8 / R9 unit reset with traffic during busy
        op_wr(1, 6'h24, 32'hF0F0_0000, "R8");
        op_wr(1, 6'h0C, 32'h3333_3333, "R8");
        op_wr(0, 6'h24, 32'h0008_0020, "R8");
        peek(0, 6'h20, 32'h00F0_0080, "R8");
        op_wr(1, 6'h00, 32'hDEAD_BEEF, "R9");
        op_wr(1, 6'h24, 32'hF000_0000, "R9");
        peek(1, 6'h24, 32'h0000_0020, "R8");
        peek(0, 6'h20, 32'h00F0_0000, "R8");
        peek(1, 6'h24, 32'h0000_0000, "R9");
        peek(1, 6'h20, 32'h00F0_0000, "R9");
        peek(0, 6'h10, 32'h0000_0000, "R9");
        check("R8", "irq b after", 32'(b_irq), 0);

        // R10 unmapped and write-only accesses
        op_wr(0, 6'h00, 32'h5555_0000, "R10");
        peek(0, 6'h00, 32'h0, "R10");
        peek(0, 6'h28, 32'h0, "R10");
        peek(0, 6'h21, 32'h0, "R10");
        op_wr(1, 6'h10, 32'h7777_7777, "R10");
        op_wr(1, 6'h3C, 32'h7777_7777, "R10");
        peek(1, 6'h10, 32'h5555_0000, "R10");
        peek(0, 6'h20, 32'h0070_0000, "R10");
        op_rd(1, 6'h10, "R10", v);

        // R11 ping-pong stream through all slots
        for (int k = 0; k < 6; k++) begin
            int n = k % 4;
            wait_flag(0, 23 - n, "R11");
            op_wr(0, 6'(4 * n), 32'hA000_0000 + k, "R11");
            wait_flag(1, 27 - n, "R11");
            op_rd(1, 6'(16 + 4 * n), "R11", v);
            check("R11", "a to b", v, 32'hA000_0000 + k);
            wait_flag(1, 23 - n, "R11");
            op_wr(1, 6'(4 * n), v ^ 32'h0000_FFFF, "R11");
            wait_flag(0, 27 - n, "R11");
            op_rd(0, 6'(16 + 4 * n), "R11", v);
            check("R11", "b to a", v, (32'hA000_0000 + k) ^ 32'h0000_FFFF);
        end
        peek(0, 6'h20, 32'h00F0_0000, "R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule